// File: doc/BRIEF.md
# Debug Window Access Service Sequencer

This block is a hardware probe engine that serves a processor's accesses to its debug memory window. It drives a JTAG scan engine through a request/done interface. Each request is either an instruction load, which uses the low 5 bits of the data word, or a 32-bit data scan. Each request returns the captured value. A run starts with a pulse on `start_i`. The engine loads the boot instruction, then polls the target's debug control register with keep-alive values that leave the status bits untouched. For every pending processor access it reads the access address, then answers it:

- For a load or fetch, it scans a word from a small register-based image into the data register.
- For a store, it captures the stored word into that image.

It then completes the access and resumes polling.

A reset seen on the target during the loop is acknowledged and polling goes on. A run ends in one of two ways. It ends with success when the debug vector address is entered a second time. It ends with a timeout after a bounded number of consecutive polls with nothing pending. Before a run, the image is filled through a load port, and any entry can be read back through a read port.

Top module: `probe_svc_seq`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o` and begins a run. `start_i` while busy is ignored. `busy_o` falls in the cycle `done_o` pulses.
- R2: The first request of every run is an instruction load of the boot code 0x0C, with bits 31:5 of `scan_wdata_o` zero.
- R3: Control, address and data registers are selected by instruction codes 0x0A, 0x08 and 0x09. An instruction load is issued only when the register needed next differs from the one last loaded.
- R4: Every poll is a control data scan writing 0x8004C000.
- R5: A captured control value with bit 31 set causes a control scan writing 0x0004C000 and a one-cycle `rst_evt_o` pulse, after which polling resumes. Bit 31 takes priority over bit 18.
- R6: A poll capture with bit 18 set (and bit 31 clear) causes an address scan, which writes 0. Bit 19 of that poll capture gives the direction: 0 means load/fetch, 1 means store.
- R7: For a load/fetch, the data scan writes the image word whose address equals the captured address. If no entry matches, it writes 0xDEADBEEF.
- R8: For a store, the data scan writes 0, and the captured word replaces the data of the matching image entry. A store with no matching entry is dropped.
- R9: Each served access is completed by a control scan writing 0x8000C000. Bit 31 of that capture is handled as in R5.
- R10: Ten consecutive polls capturing neither bit 31 nor bit 18 end the run with `status_o` = 2 (timeout). The count restarts from zero after each completion whose capture has bit 31 clear.
- R11: An address capture of 0xFF200200 when that address was already served in this run ends the run at once with `status_o` = 1 (success), with no data or completion scan.
- R12: `scan_req_o` stays high until `scan_done_i`, is low in the cycle after each `scan_done_i`, and `done_o` pulses in the cycle after the final `scan_done_i`.
- R13: `img_we_i` writes address tag and data into entry `img_idx_i` and marks it valid. `img_rdata_o` shows the data of entry `img_ridx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | Run result: 1 success, 2 timeout |
| rst_evt_o | output | 1 | One-cycle pulse per target reset seen |
| scan_req_o | output | 1 | Scan request |
| scan_ir_o | output | 1 | 1 instruction load, 0 data scan |
| scan_wdata_o | output | 32 | Instruction code (bits 4:0) or data to shift in |
| scan_done_i | input | 1 | Scan finished, capture valid |
| scan_rdata_i | input | 32 | Captured value |
| img_we_i | input | 1 | Image load strobe |
| img_idx_i | input | $clog2(ENTRIES) (3) | Image entry to load |
| img_addr_i | input | 32 | Address tag to load |
| img_data_i | input | 32 | Data word to load |
| img_ridx_i | input | $clog2(ENTRIES) (3) | Image entry to read back |
| img_rdata_o | output | 32 | Data of entry `img_ridx_i` |

## Verification
A new scan request appears two cycles after the `scan_done_i` cycle, because of one registered gap cycle. `done_o` and `rst_evt_o` are due exactly one cycle after the `scan_done_i` that caused them. The bench's scan model stamps the cycle in which it drives each done. It compares the cycle in which `done_o` is seen against that stamp plus one. The bench logs every instruction code and every value written to control and data scans in order. Those logs are checked after the run, so the sequence checks do not depend on the scan latency.

// File: rtl/probe_svc_pkg.sv
package probe_svc_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned IR_W = 5;

  localparam logic [IR_W-1:0] IR_BOOT = 5'h0C;
  localparam logic [IR_W-1:0] IR_ADDR = 5'h08;
  localparam logic [IR_W-1:0] IR_DATA = 5'h09;
  localparam logic [IR_W-1:0] IR_CTRL = 5'h0A;

  localparam logic [DW-1:0] CTRL_POLL = 32'h8004_C000;
  localparam logic [DW-1:0] CTRL_ACK  = 32'h0004_C000;
  localparam logic [DW-1:0] CTRL_CMPL = 32'h8000_C000;
  localparam logic [DW-1:0] FILL_WORD = 32'hDEAD_BEEF;
  localparam logic [DW-1:0] VEC_ADDR  = 32'hFF20_0200;

  localparam int unsigned B_ROCC = 31;
  localparam int unsigned B_PEND = 18;
  localparam int unsigned B_RNW  = 19;

  typedef enum logic [1:0] {
    ST_NONE    = 2'd0,
    ST_SUCCESS = 2'd1,
    ST_TIMEOUT = 2'd2
  } run_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_BOOT, S_POLL, S_ACK, S_ADDR, S_DATA, S_CMPL
  } seq_state_e;
endpackage

// File: rtl/probe_img_store.sv
module probe_img_store import probe_svc_pkg::*; #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [DW-1:0]    ld_addr_i,
  input  logic [DW-1:0]    ld_data_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [DW-1:0]    rb_data_o,
  input  logic [DW-1:0]    lk_addr_i,
  output logic             lk_hit_o,
  output logic [DW-1:0]    lk_data_o,
  input  logic             st_we_i,
  input  logic [DW-1:0]    st_data_i
);
  logic [DW-1:0]    tag_q [ENTRIES];
  logic [DW-1:0]    dat_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit;
  logic [IDX_W-1:0] hit_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = vld_q[g] && (tag_q[g] == lk_addr_i);
  end

  // lowest matching entry wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign lk_hit_o  = |hit;
  assign lk_data_o = lk_hit_o ? dat_q[hit_idx] : FILL_WORD;
  assign rb_data_o = dat_q[rb_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (ld_we_i) begin
      vld_q[ld_idx_i] <= 1'b1;
      tag_q[ld_idx_i] <= ld_addr_i;
      dat_q[ld_idx_i] <= ld_data_i;
    end else if (st_we_i && lk_hit_o) begin
      dat_q[hit_idx] <= st_data_i;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_i |=> vld_q[$past(ld_idx_i)] && dat_q[$past(ld_idx_i)] == $past(ld_data_i)); // R13
  AST_STORE_MISS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !lk_hit_o && !ld_we_i) |=> $stable(vld_q)); // R8
endmodule

// File: rtl/probe_poll_cnt.sv
module probe_poll_cnt #(
  parameter int unsigned LIMIT = 10,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = inc_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || expire_o) cnt_q <= '0;
    else if (inc_i)          cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT)); // R10
endmodule

// File: rtl/probe_svc_fsm.sv
module probe_svc_fsm import probe_svc_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic          rst_evt_o,
  output logic          scan_req_o,
  output logic          scan_ir_o,
  output logic [DW-1:0] scan_wdata_o,
  input  logic          scan_done_i,
  input  logic [DW-1:0] scan_rdata_i,
  output logic [DW-1:0] lk_addr_o,
  input  logic [DW-1:0] lk_data_i,
  output logic          st_we_o,
  output logic [DW-1:0] st_data_o,
  output logic          cnt_clr_o,
  output logic          cnt_inc_o,
  input  logic          cnt_expire_i
);
  seq_state_e      state_q;
  logic [IR_W-1:0] cur_ir_q, need_ir;
  logic [DW-1:0]   dr_out, addr_q;
  logic            gap_q, rnw_q, seen_vec_q, done_q, rst_evt_q;
  run_status_e     status_q;
  logic            do_ir, req, xfer, dxfer;

  always_comb begin
    unique case (state_q)
      S_BOOT:  need_ir = IR_BOOT;
      S_ADDR:  need_ir = IR_ADDR;
      S_DATA:  need_ir = IR_DATA;
      default: need_ir = IR_CTRL;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_POLL:  dr_out = CTRL_POLL;
      S_ACK:   dr_out = CTRL_ACK;
      S_CMPL:  dr_out = CTRL_CMPL;
      S_DATA:  dr_out = rnw_q ? '0 : lk_data_i;
      default: dr_out = '0;
    endcase
  end

  assign do_ir = (state_q == S_BOOT) || (cur_ir_q != need_ir);
  assign req   = (state_q != S_IDLE) && !gap_q;
  assign xfer  = req && scan_done_i;
  assign dxfer = xfer && !do_ir;

  assign scan_req_o   = req;
  assign scan_ir_o    = do_ir;
  assign scan_wdata_o = do_ir ? {{(DW-IR_W){1'b0}}, need_ir} : dr_out;

  assign lk_addr_o = addr_q;
  assign st_we_o   = dxfer && (state_q == S_DATA) && rnw_q;
  assign st_data_o = scan_rdata_i;

  assign cnt_inc_o = dxfer && (state_q == S_POLL) &&
                     !scan_rdata_i[B_ROCC] && !scan_rdata_i[B_PEND];
  assign cnt_clr_o = ((state_q == S_IDLE) && start_i) ||
                     (dxfer && (state_q == S_CMPL) && !scan_rdata_i[B_ROCC]);

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign status_o  = status_q;
  assign rst_evt_o = rst_evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cur_ir_q   <= '0;
      addr_q     <= '0;
      gap_q      <= 1'b0;
      rnw_q      <= 1'b0;
      seen_vec_q <= 1'b0;
      done_q     <= 1'b0;
      rst_evt_q  <= 1'b0;
      status_q   <= ST_NONE;
    end else begin
      done_q    <= 1'b0;
      rst_evt_q <= 1'b0;
      gap_q     <= xfer;
      if (state_q == S_IDLE) begin
        if (start_i) begin
          state_q    <= S_BOOT;
          seen_vec_q <= 1'b0;
          status_q   <= ST_NONE;
        end
      end else if (xfer && do_ir) begin
        cur_ir_q <= need_ir;
        if (state_q == S_BOOT) state_q <= S_POLL;
      end else if (dxfer) begin
        unique case (state_q)
          S_POLL: begin
            if (scan_rdata_i[B_ROCC]) begin
              rst_evt_q <= 1'b1;
              state_q   <= S_ACK;
            end else if (scan_rdata_i[B_PEND]) begin
              rnw_q   <= scan_rdata_i[B_RNW];
              state_q <= S_ADDR;
            end else if (cnt_expire_i) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= ST_TIMEOUT;
            end
          end
          S_ACK: state_q <= S_POLL;
          S_ADDR: begin
            addr_q <= scan_rdata_i;
            if (scan_rdata_i == VEC_ADDR && seen_vec_q) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= ST_SUCCESS;
            end else begin
              seen_vec_q <= seen_vec_q || (scan_rdata_i == VEC_ADDR);
              state_q    <= S_DATA;
            end
          end
          S_DATA: state_q <= S_CMPL;
          S_CMPL: begin
            if (scan_rdata_i[B_ROCC]) begin
              rst_evt_q <= 1'b1;
              state_q   <= S_ACK;
            end else begin
              state_q <= S_POLL;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_req_o && !scan_done_i) |=> scan_req_o); // R12
  AST_REQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_req_o && scan_done_i) |=> !scan_req_o); // R12
  AST_BOOT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> scan_req_o && scan_ir_o && scan_wdata_o == DW'(IR_BOOT)); // R2
  AST_IR_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_req_o && scan_ir_o) |-> scan_wdata_o[DW-1:IR_W] == '0); // R2
  AST_DONE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o == ST_SUCCESS || status_o == ST_TIMEOUT)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R1
  AST_DONE_AFTER_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(scan_done_i)); // R12
endmodule

// File: rtl/probe_svc_seq.sv
module probe_svc_seq import probe_svc_pkg::*; #(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned POLL_LIMIT = 10,
  localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic             rst_evt_o,
  output logic             scan_req_o,
  output logic             scan_ir_o,
  output logic [31:0]      scan_wdata_o,
  input  logic             scan_done_i,
  input  logic [31:0]      scan_rdata_i,
  input  logic             img_we_i,
  input  logic [IDX_W-1:0] img_idx_i,
  input  logic [31:0]      img_addr_i,
  input  logic [31:0]      img_data_i,
  input  logic [IDX_W-1:0] img_ridx_i,
  output logic [31:0]      img_rdata_o
);
  logic [DW-1:0] lk_addr, lk_data, st_data;
  logic          lk_hit, st_we, cnt_clr, cnt_inc, cnt_expire;

  probe_svc_fsm i_fsm (
    .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .status_o, .rst_evt_o,
    .scan_req_o, .scan_ir_o, .scan_wdata_o, .scan_done_i, .scan_rdata_i,
    .lk_addr_o(lk_addr), .lk_data_i(lk_data),
    .st_we_o(st_we), .st_data_o(st_data),
    .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .cnt_expire_i(cnt_expire)
  );

  probe_img_store #(.ENTRIES(ENTRIES)) i_img (
    .clk_i, .rst_ni,
    .ld_we_i(img_we_i), .ld_idx_i(img_idx_i), .ld_addr_i(img_addr_i), .ld_data_i(img_data_i),
    .rb_idx_i(img_ridx_i), .rb_data_o(img_rdata_o),
    .lk_addr_i(lk_addr), .lk_hit_o(lk_hit), .lk_data_o(lk_data),
    .st_we_i(st_we), .st_data_i(st_data)
  );

  probe_poll_cnt #(.LIMIT(POLL_LIMIT)) i_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(cnt_inc), .expire_o(cnt_expire)
  );

  AST_STORE_ONLY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we |-> scan_done_i && !scan_ir_o); // R8
  AST_HIT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit |-> lk_data == FILL_WORD); // R7
endmodule

// File: tb/test_probe_svc_seq.sv
module test_probe_svc_seq;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic        busy_o, done_o, rst_evt_o, scan_req_o, scan_ir_o;
  logic [1:0]  status_o;
  logic [31:0] scan_wdata_o, scan_rdata_i = '0;
  logic        scan_done_i = 1'b0;
  logic        img_we_i = 1'b0;
  logic [2:0]  img_idx_i = '0, img_ridx_i = '0;
  logic [31:0] img_addr_i = '0, img_data_i = '0, img_rdata_o;

  always #4 clk_i = ~clk_i;

  probe_svc_seq i_probe_svc_seq (.*);

  int checks = 0, errors = 0, cyc = 0, drv_cyc = 0, done_n = 0, rst_evts = 0, wcnt = 0;
  logic [31:0] ctrl_resp [40], addr_resp [8], data_resp [8];
  logic [31:0] ctrl_log [40], data_log [8];
  logic [4:0]  ir_log [16], tgt_ir = '0;
  int ci = 0, ai = 0, di = 0, ir_n = 0;
  logic [1:0] last_status;

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  always @(posedge clk_i) cyc++;

  // scan engine model, latency 2
  always @(negedge clk_i) begin
    if (scan_done_i) scan_done_i = 1'b0;
    else if (scan_req_o) begin
      wcnt++;
      if (wcnt == 2) begin
        wcnt = 0;
        scan_rdata_i = '0;
        if (scan_ir_o) begin
          tgt_ir = scan_wdata_o[4:0];
          if (ir_n < 16) ir_log[ir_n] = tgt_ir;
          ir_n++;
        end else if (tgt_ir == 5'h0A) begin
          if (ci < 40) begin ctrl_log[ci] = scan_wdata_o; scan_rdata_i = ctrl_resp[ci]; end
          ci++;
        end else if (tgt_ir == 5'h08) begin
          if (ai < 8) scan_rdata_i = addr_resp[ai];
          ai++;
        end else if (tgt_ir == 5'h09) begin
          if (di < 8) begin data_log[di] = scan_wdata_o; scan_rdata_i = data_resp[di]; end
          di++;
        end
        scan_done_i = 1'b1;
        drv_cyc = cyc;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_evt_o) rst_evts++;
    if (done_o) begin
      done_n++;
      last_status = status_o;
      check(cyc == drv_cyc + 1, "R12 done_o cycle", cyc, drv_cyc + 1);
    end
  end

  task automatic clear_bench();
    for (int i = 0; i < 40; i++) begin ctrl_resp[i] = '0; ctrl_log[i] = '0; end
    for (int i = 0; i < 8; i++) begin addr_resp[i] = '0; data_resp[i] = '0; data_log[i] = '0; end
    ci = 0; ai = 0; di = 0; ir_n = 0; rst_evts = 0;
  endtask

  task automatic load_img(input logic [2:0] idx, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i);
    img_we_i = 1'b1; img_idx_i = idx; img_addr_i = a; img_data_i = d;
    @(negedge clk_i);
    img_we_i = 1'b0;
  endtask

  task automatic run(input bit restart_mid);
    int n0;
    n0 = done_n;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check(busy_o == 1'b1, "R1 busy after start", {31'b0, busy_o}, 32'd1);
    if (restart_mid) begin
      repeat (20) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    for (int i = 0; i < 3000 && done_n == n0; i++) @(negedge clk_i);
    check(done_n == n0 + 1, "R1 run ended once", done_n - n0, 32'd1);
    check(busy_o == 1'b0, "R1 idle after done", {31'b0, busy_o}, 32'd0);
  endtask

  task automatic t_reset();
    check(!busy_o && !done_o && !scan_req_o, "R1 reset state",
          {29'b0, busy_o, done_o, scan_req_o}, 32'd0);
  endtask

  task automatic t_timeout();
    clear_bench();
    run(1'b1);
    check(ir_n == 2 && ir_log[0] == 5'h0C && ir_log[1] == 5'h0A, "R2 R3 boot then control only",
          {ir_log[0], ir_log[1], ir_n[21:0]}, {5'h0C, 5'h0A, 22'd2});
    check(ci == 10, "R10 ten empty polls", ci, 32'd10);
    for (int i = 0; i < 10; i++)
      check(ctrl_log[i] == 32'h8004C000, "R4 poll value", ctrl_log[i], 32'h8004C000);
    check(last_status == 2'd2, "R10 timeout status", {30'b0, last_status}, 32'd2);
  endtask

  task automatic t_read_success();
    clear_bench();
    load_img(3'd0, 32'hFF200200, 32'h0000000F);
    ctrl_resp[0] = 32'h00040000; ctrl_resp[2] = 32'h00040000;
    addr_resp[0] = 32'hFF200200; addr_resp[1] = 32'hFF200200;
    run(1'b0);
    check(data_log[0] == 32'h0000000F, "R7 image word supplied", data_log[0], 32'h0000000F);
    check(ctrl_log[1] == 32'h8000C000, "R9 completion value", ctrl_log[1], 32'h8000C000);
    check(di == 1 && ci == 3 && ai == 2, "R11 no scan after second vector",
          {ci[7:0], ai[7:0], di[15:0]}, {8'd3, 8'd2, 16'd1});
    check(ir_n == 6, "R3 instruction loads only on change", ir_n, 32'd6);
    check(last_status == 2'd1, "R11 success status", {30'b0, last_status}, 32'd1);
  endtask

  task automatic t_store_miss();
    clear_bench();
    load_img(3'd1, 32'hFF200000, 32'hAAAA5555);
    ctrl_resp[5] = 32'h000C0000; ctrl_resp[7] = 32'h00040000;
    addr_resp[0] = 32'hFF200000; addr_resp[1] = 32'hFF200010;
    data_resp[0] = 32'h12345678;
    run(1'b0);
    check(data_log[0] == 32'h0, "R8 store scans zero", data_log[0], 32'h0);
    @(negedge clk_i); img_ridx_i = 3'd1; #1;
    check(img_rdata_o == 32'h12345678, "R8 R13 store captured", img_rdata_o, 32'h12345678);
    check(data_log[1] == 32'hDEADBEEF, "R7 miss word", data_log[1], 32'hDEADBEEF);
    check(ci == 19, "R10 count cleared after access", ci, 32'd19);
    check(ai == 2, "R6 address scan per access", ai, 32'd2);
    check(last_status == 2'd2, "R10 timeout after service", {30'b0, last_status}, 32'd2);
  endtask

  task automatic t_target_reset();
    logic [31:0] exp [6];
    clear_bench();
    exp = '{32'h8004C000, 32'h0004C000, 32'h8004C000, 32'h8000C000, 32'h0004C000, 32'h8004C000};
    ctrl_resp[0] = 32'h80040000; ctrl_resp[2] = 32'h00040000;
    ctrl_resp[3] = 32'h80000000; ctrl_resp[5] = 32'h00040000;
    addr_resp[0] = 32'hFF200200; addr_resp[1] = 32'hFF200200;
    run(1'b0);
    for (int i = 0; i < 6; i++)
      check(ctrl_log[i] == exp[i], "R5 R9 control sequence", ctrl_log[i], exp[i]);
    check(rst_evts == 2, "R5 reset events", rst_evts, 32'd2);
    check(data_log[0] == 32'h0000000F, "R6 R7 load after reset", data_log[0], 32'h0000000F);
    check(last_status == 2'd1, "R11 success after resets", {30'b0, last_status}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_timeout();
    t_read_success();
    t_store_miss();
    t_target_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule